// File: doc/BRIEF.md
# Instruction Cache Parity Recovery Controller

This controller sits between the instruction fetch stage and a first-level instruction cache. Each 64-bit doubleword in that cache carries one even-parity bit. Every accepted fetch reads the array in the same cycle and checks the parity. A clean doubleword is returned to the fetch stage on the next cycle.

When the parity check fails, the controller stops accepting fetches and requests the whole containing line from the second-level cache. It then writes the returned beats back into the array in ascending order. A beat that arrives without an uncorrectable-error mark is stored with good parity. A marked beat is stored with inverted parity and keeps its error-mark identifier beside it. The beat that the stalled fetch asked for is forwarded with an error flag and its identifier. A repair done by the refill is invisible to software.

The identifier travels down the pipeline in a sideband. A fault is raised only when the retire port reports that a poisoned instruction completed. That event also latches the identifier into a status register, which software clears by a write-one-to-clear pulse. Poisoned instructions that are squashed and never retire leave no trace.

Top module: `icp_recovery_ctl`

## Requirements
- R1: A fetch accepted while `fch_rdy` is high whose array doubleword has even parity (stored bit equals the XOR of the 64 data bits) is answered on the following cycle. The answer has `out_vld`=1, the array data, `out_err`=0 and `out_mid`=0, and no lower-cache request is made.
- R2: A fetch whose array doubleword fails the parity check produces exactly one single-cycle `l2_req_vld` pulse, carrying the line index (upper address bits). `fch_rdy` stays low from the cycle after detection until the last beat of the line has been consumed.
- R3: The refill writes all `LINE_DW` beats of the line to array address {line, beat} in ascending beat order. Unmarked beats are stored with parity equal to the XOR of their data and with identifier 0.
- R4: A beat that arrives with `l2_rsp_ue`=1 is stored with parity equal to the inverted XOR of its data, together with its `l2_rsp_mid`.
- R5: During a refill, the beat whose offset (low address bits) matches the failing fetch is forwarded on the cycle after it is consumed. It carries `out_err` equal to its mark and `out_mid` equal to its identifier, or 0 when unmarked. Each fetch gets exactly one answer.
- R6: A fetch or refill by itself never raises `flt_vld` and never changes `sts_ue` or `sts_mid`.
- R7: A beat is consumed only in a cycle with both `l2_rsp_vld` and `l2_rsp_rdy` high. Idle cycles in the middle of the returned beats are tolerated.
- R8: While a refill is in progress, fetches are not accepted. A parity error in a fetch presented during that time starts no second request and gets no answer.
- R9: A cycle with `ret_vld`=1 and `ret_err`=1 raises `flt_vld` for exactly the next cycle. In that same cycle `sts_ue` becomes 1 and `sts_mid` becomes the `ret_mid` that came with the completion.
- R10: A completion with `ret_err`=0, or a poisoned fetch that never completes, raises no fault.
- R11: `sts_clr` clears `sts_ue` and `sts_mid` on the next cycle. A poisoned completion in the same cycle takes precedence.
- R12: After reset: `fch_rdy`=1, and `l2_req_vld`, `out_vld`, `flt_vld` and `sts_ue` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fch_vld | input | 1 | Fetch request valid |
| fch_addr | input | IDX_W+OFF_W | Fetch doubleword address {line, offset} |
| fch_rdy | output | 1 | Fetch request accepted when high |
| arr_raddr | output | IDX_W+OFF_W | Array read address |
| arr_rdata | input | DW_W | Array read data |
| arr_rpar | input | 1 | Array read parity bit |
| arr_rmid | input | MID_W | Array read identifier sideband |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | IDX_W+OFF_W | Array write address |
| arr_wdata | output | DW_W | Array write data |
| arr_wpar | output | 1 | Array write parity bit |
| arr_wmid | output | MID_W | Array write identifier |
| l2_req_vld | output | 1 | Line refill request pulse |
| l2_req_line | output | IDX_W | Line index to refill |
| l2_rsp_vld | input | 1 | Refill beat valid |
| l2_rsp_rdy | output | 1 | Refill beat accepted when high |
| l2_rsp_data | input | DW_W | Refill beat data |
| l2_rsp_ue | input | 1 | Refill beat carries an uncorrectable mark |
| l2_rsp_mid | input | MID_W | Refill beat error-mark identifier |
| out_vld | output | 1 | Fetch answer valid |
| out_data | output | DW_W | Fetch answer data |
| out_err | output | 1 | Fetch answer is poisoned |
| out_mid | output | MID_W | Identifier of a poisoned answer |
| ret_vld | input | 1 | Instruction completion |
| ret_err | input | 1 | Completing instruction was poisoned |
| ret_mid | input | MID_W | Identifier of the completing instruction |
| flt_vld | output | 1 | Precise instruction access fault |
| sts_ue | output | 1 | Status: marked error seen |
| sts_mid | output | MID_W | Status: logged identifier |
| sts_clr | input | 1 | Write-one-to-clear pulse for the status |

## Verification
The bench builds the block with 64-bit doublewords, 8-beat lines, 14-bit identifiers and a 4-bit line index. The array then holds only 128 doublewords and can be modelled in full. After each refill, every beat of the line can be read back for data, parity and identifier. The eight beats still cover the first offset, the last offset, mid-line offsets and beats on both sides of the requested one. Lines 0 to 15 include the top index, which checks the address split at its upper boundary.

// File: rtl/icp_pkg.sv
package icp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2
  } icp_state_e;
endpackage

// File: rtl/icp_parity.sv
module icp_parity #(
  parameter int W = 64
) (
  input  logic [W-1:0] data,
  output logic         par
);
  // even parity over the whole word
  assign par = ^data;
endmodule

// File: rtl/icp_refill_seq.sv
module icp_refill_seq
  import icp_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int LINE_DW = 8,
  parameter int OFF_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fch_vld,
  input  logic [IDX_W+OFF_W-1:0] fch_addr,
  input  logic                   rd_bad,
  input  logic                   rsp_vld,
  output logic                   fch_rdy,
  output logic                   req_vld,
  output logic                   rsp_rdy,
  output logic                   fill_fire,
  output logic                   fill_hit,
  output logic [IDX_W-1:0]       line,
  output logic [OFF_W-1:0]       beat
);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_DW - 1);

  icp_state_e       st_q, st_d;
  logic [IDX_W-1:0] line_q, line_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [OFF_W-1:0] beat_q, beat_d;
  logic             cap_en;

  assign fch_rdy   = (st_q == ST_IDLE);
  assign req_vld   = (st_q == ST_REQ);
  assign rsp_rdy   = (st_q == ST_FILL);
  assign fill_fire = rsp_rdy & rsp_vld;
  assign fill_hit  = fill_fire & (beat_q == off_q);
  assign line      = line_q;
  assign beat      = beat_q;

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    cap_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fch_vld && rd_bad) begin
          st_d   = ST_REQ;
          cap_en = 1'b1;
          beat_d = '0;
        end
      end
      ST_REQ:  st_d = ST_FILL;
      ST_FILL: begin
        if (rsp_vld) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign line_d = fch_addr[IDX_W+OFF_W-1:OFF_W];
  assign off_d  = fch_addr[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      line_q <= '0;
      off_q  <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      if (cap_en) begin
        line_q <= line_d;
        off_q  <= off_d;
      end
    end
  end
endmodule

// File: rtl/icp_fault_log.sv
module icp_fault_log #(
  parameter int MID_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_vld,
  input  logic             ret_err,
  input  logic [MID_W-1:0] ret_mid,
  input  logic             sts_clr,
  output logic             flt_vld,
  output logic             sts_ue,
  output logic [MID_W-1:0] sts_mid
);
  logic             set;
  logic             flt_d, ue_d;
  logic [MID_W-1:0] mid_d;

  assign set = ret_vld & ret_err;

  always_comb begin
    flt_d = set;
    ue_d  = set | (sts_ue & ~sts_clr);
    if (set)          mid_d = ret_mid;
    else if (sts_clr) mid_d = '0;
    else              mid_d = sts_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_vld <= 1'b0;
      sts_ue  <= 1'b0;
      sts_mid <= '0;
    end else begin
      flt_vld <= flt_d;
      sts_ue  <= ue_d;
      sts_mid <= mid_d;
    end
  end
endmodule

// File: rtl/icp_recovery_ctl.sv
module icp_recovery_ctl #(
  parameter int DW_W    = 64,
  parameter int LINE_DW = 8,
  parameter int IDX_W   = 6,
  parameter int MID_W   = 14,
  parameter int OFF_W   = $clog2(LINE_DW),
  parameter int AW      = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fch_vld,
  input  logic [AW-1:0]    fch_addr,
  output logic             fch_rdy,
  output logic [AW-1:0]    arr_raddr,
  input  logic [DW_W-1:0]  arr_rdata,
  input  logic             arr_rpar,
  input  logic [MID_W-1:0] arr_rmid,
  output logic             arr_we,
  output logic [AW-1:0]    arr_waddr,
  output logic [DW_W-1:0]  arr_wdata,
  output logic             arr_wpar,
  output logic [MID_W-1:0] arr_wmid,
  output logic             l2_req_vld,
  output logic [IDX_W-1:0] l2_req_line,
  input  logic             l2_rsp_vld,
  output logic             l2_rsp_rdy,
  input  logic [DW_W-1:0]  l2_rsp_data,
  input  logic             l2_rsp_ue,
  input  logic [MID_W-1:0] l2_rsp_mid,
  output logic             out_vld,
  output logic [DW_W-1:0]  out_data,
  output logic             out_err,
  output logic [MID_W-1:0] out_mid,
  input  logic             ret_vld,
  input  logic             ret_err,
  input  logic [MID_W-1:0] ret_mid,
  output logic             flt_vld,
  output logic             sts_ue,
  output logic [MID_W-1:0] sts_mid,
  input  logic             sts_clr
);
  logic             rd_calc, wr_calc, rd_bad;
  logic             fill_fire, fill_hit;
  logic [IDX_W-1:0] line;
  logic [OFF_W-1:0] beat;
  logic             clean_hit;

  // read side check and write side generator
  icp_parity #(.W(DW_W)) u_chk (.data(arr_rdata),   .par(rd_calc));
  icp_parity #(.W(DW_W)) u_gen (.data(l2_rsp_data), .par(wr_calc));

  assign arr_raddr = fch_addr;
  assign rd_bad    = rd_calc ^ arr_rpar;

  icp_refill_seq #(.IDX_W(IDX_W), .LINE_DW(LINE_DW), .OFF_W(OFF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fch_vld   (fch_vld),
    .fch_addr  (fch_addr),
    .rd_bad    (rd_bad),
    .rsp_vld   (l2_rsp_vld),
    .fch_rdy   (fch_rdy),
    .req_vld   (l2_req_vld),
    .rsp_rdy   (l2_rsp_rdy),
    .fill_fire (fill_fire),
    .fill_hit  (fill_hit),
    .line      (line),
    .beat      (beat)
  );

  assign l2_req_line = line;

  // refill write port: marked beats keep their identifier and get inverted parity
  assign arr_we    = fill_fire;
  assign arr_waddr = {line, beat};
  assign arr_wdata = l2_rsp_data;
  assign arr_wpar  = wr_calc ^ l2_rsp_ue;
  assign arr_wmid  = l2_rsp_ue ? l2_rsp_mid : '0;

  // fetch answer register
  logic             ov_d;
  logic [DW_W-1:0]  od_d;
  logic             oe_d;
  logic [MID_W-1:0] om_d;
  logic             o_en;

  assign clean_hit = fch_vld & fch_rdy & ~rd_bad;

  always_comb begin
    ov_d = 1'b0;
    o_en = 1'b0;
    od_d = out_data;
    oe_d = out_err;
    om_d = out_mid;
    if (clean_hit) begin
      ov_d = 1'b1;
      o_en = 1'b1;
      od_d = arr_rdata;
      oe_d = 1'b0;
      om_d = '0;
    end else if (fill_hit) begin
      ov_d = 1'b1;
      o_en = 1'b1;
      od_d = l2_rsp_data;
      oe_d = l2_rsp_ue;
      om_d = arr_wmid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      out_err  <= 1'b0;
      out_mid  <= '0;
    end else begin
      out_vld <= ov_d;
      if (o_en) begin
        out_data <= od_d;
        out_err  <= oe_d;
        out_mid  <= om_d;
      end
    end
  end

  icp_fault_log #(.MID_W(MID_W)) u_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .ret_vld (ret_vld),
    .ret_err (ret_err),
    .ret_mid (ret_mid),
    .sts_clr (sts_clr),
    .flt_vld (flt_vld),
    .sts_ue  (sts_ue),
    .sts_mid (sts_mid)
  );
endmodule

// File: rtl/icp_recovery_chk.sv
module icp_recovery_chk #(
  parameter int DW_W  = 64,
  parameter int MID_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fch_rdy,
  input logic             l2_req_vld,
  input logic             l2_rsp_vld,
  input logic             l2_rsp_rdy,
  input logic             l2_rsp_ue,
  input logic             arr_we,
  input logic [DW_W-1:0]  arr_wdata,
  input logic             arr_wpar,
  input logic             ret_vld,
  input logic             ret_err,
  input logic [MID_W-1:0] ret_mid,
  input logic             flt_vld,
  input logic             sts_ue,
  input logic [MID_W-1:0] sts_mid,
  input logic             sts_clr
);
  a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_vld |=> !l2_req_vld && !fch_rdy);

  a_r2_stall_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_vld |-> !fch_rdy);

  a_r8_no_fetch_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    l2_rsp_rdy |-> !fch_rdy);

  a_r7_write_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> l2_rsp_vld && l2_rsp_rdy);

  a_r3_clean_parity: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we && !l2_rsp_ue |-> arr_wpar == ^arr_wdata);

  a_r4_poison_parity: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we && l2_rsp_ue |-> arr_wpar != ^arr_wdata);

  a_r9_fault_logged: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld && ret_err |=> flt_vld && sts_ue && sts_mid == $past(ret_mid));

  a_r10_no_spurious_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_vld && ret_err) |=> !flt_vld);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr && !(ret_vld && ret_err) |=> !sts_ue && sts_mid == '0);

  a_r6_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_vld && ret_err) && !sts_clr |=> $stable(sts_ue) && $stable(sts_mid));
endmodule

bind icp_recovery_ctl icp_recovery_chk #(.DW_W(DW_W), .MID_W(MID_W)) u_chk_b (
  .clk        (clk),
  .rst_n      (rst_n),
  .fch_rdy    (fch_rdy),
  .l2_req_vld (l2_req_vld),
  .l2_rsp_vld (l2_rsp_vld),
  .l2_rsp_rdy (l2_rsp_rdy),
  .l2_rsp_ue  (l2_rsp_ue),
  .arr_we     (arr_we),
  .arr_wdata  (arr_wdata),
  .arr_wpar   (arr_wpar),
  .ret_vld    (ret_vld),
  .ret_err    (ret_err),
  .ret_mid    (ret_mid),
  .flt_vld    (flt_vld),
  .sts_ue     (sts_ue),
  .sts_mid    (sts_mid),
  .sts_clr    (sts_clr)
);

// File: tb/sim_icp_recovery_ctl.sv
`timescale 1ns/1ps
module sim_icp_recovery_ctl;
  localparam int DW_W = 64, LINE_DW = 8, IDX_W = 4, MID_W = 14;
  localparam int OFF_W = 3, AW = IDX_W + OFF_W, NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic fch_vld = 0; logic [AW-1:0] fch_addr = '0; logic fch_rdy;
  logic [AW-1:0] arr_raddr, arr_waddr; logic [DW_W-1:0] arr_rdata, arr_wdata;
  logic arr_rpar, arr_we, arr_wpar; logic [MID_W-1:0] arr_rmid, arr_wmid;
  logic l2_req_vld, l2_rsp_rdy; logic [IDX_W-1:0] l2_req_line;
  logic l2_rsp_vld = 0, l2_rsp_ue = 0; logic [DW_W-1:0] l2_rsp_data = '0;
  logic [MID_W-1:0] l2_rsp_mid = '0;
  logic out_vld, out_err; logic [DW_W-1:0] out_data; logic [MID_W-1:0] out_mid;
  logic ret_vld = 0, ret_err = 0, sts_clr = 0; logic [MID_W-1:0] ret_mid = '0;
  logic flt_vld, sts_ue; logic [MID_W-1:0] sts_mid;

  icp_recovery_ctl #(.DW_W(DW_W), .LINE_DW(LINE_DW), .IDX_W(IDX_W), .MID_W(MID_W)) u0 (.*);

  // array model
  logic [DW_W-1:0] m_data [NW];
  logic m_par [NW];
  logic [MID_W-1:0] m_mid [NW];
  assign arr_rdata = m_data[arr_raddr];
  assign arr_rpar  = m_par[arr_raddr];
  assign arr_rmid  = m_mid[arr_raddr];
  always @(posedge clk) if (arr_we) begin
    m_data[arr_waddr] <= arr_wdata; m_par[arr_waddr] <= arr_wpar; m_mid[arr_waddr] <= arr_wmid;
  end

  int n_tests = 0, n_fail = 0;
  int n_out = 0, n_req = 0, n_flt = 0;
  logic [DW_W-1:0] g_data; logic g_err; logic [MID_W-1:0] g_mid;

  always @(negedge clk) begin
    if (out_vld) begin n_out++; g_data = out_data; g_err = out_err; g_mid = out_mid; end
    if (l2_req_vld) n_req++;
    if (flt_vld) n_flt++;
  end

  function automatic logic [DW_W-1:0] pat(input int a);
    return {16'hC0DE, 8'(a), 8'h5A, 32'(a) * 32'h0101_0101 + 32'h0F0F};
  endfunction
  function automatic logic [DW_W-1:0] l2pat(input int a);
    return pat(a) ^ 64'hFFFF_0000_0F0F_F0F0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin n_fail++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic preload(input int ln);
    for (int b = 0; b < LINE_DW; b++) begin
      m_data[ln*LINE_DW+b] = pat(ln*LINE_DW+b);
      m_par[ln*LINE_DW+b]  = ^pat(ln*LINE_DW+b);
      m_mid[ln*LINE_DW+b]  = '0;
    end
  endtask

  task automatic wait_req(input int ln);
    int t = 0;
    while (!l2_req_vld && t < 50) begin @(negedge clk); t++; end
    chk(l2_req_vld && l2_req_line == IDX_W'(ln), "R2 request line", 64'(l2_req_line), 64'(ln));
  endtask

  task automatic send_beats(input int ln, input logic [7:0] ue, input logic gap);
    int b = 0;
    while (b < LINE_DW) begin
      @(negedge clk);
      if (gap && b == 3) begin l2_rsp_vld = 0; gap = 0; end
      else begin
        l2_rsp_vld = 1; l2_rsp_data = l2pat(ln*LINE_DW+b);
        l2_rsp_ue = ue[b]; l2_rsp_mid = MID_W'(14'h100 + b);
        if (l2_rsp_rdy) b++;
      end
    end
    @(negedge clk); l2_rsp_vld = 0; l2_rsp_ue = 0;
  endtask

  // vector: line[16:13] off[12:10] corrupt[9] ue[8:1] gap[0]
  localparam logic [16:0] VEC [6] = '{
    {4'd1,  3'd2, 1'b0, 8'h00, 1'b0},
    {4'd2,  3'd0, 1'b1, 8'h00, 1'b0},
    {4'd3,  3'd7, 1'b1, 8'h00, 1'b1},
    {4'd4,  3'd5, 1'b1, 8'h20, 1'b0},
    {4'd5,  3'd1, 1'b1, 8'h81, 1'b1},
    {4'd15, 3'd3, 1'b0, 8'h00, 1'b0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NW; i++) begin m_data[i] = '0; m_par[i] = 0; m_mid[i] = '0; end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(fch_rdy && !l2_req_vld && !out_vld && !flt_vld && !sts_ue, "R12 reset state",
        {59'd0, fch_rdy, l2_req_vld, out_vld, flt_vld, sts_ue}, 64'h10);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      int ln, off, a, o0, r0, f0;
      logic cor, gp; logic [7:0] ue;
      ln = int'(VEC[v][16:13]); off = int'(VEC[v][12:10]); cor = VEC[v][9];
      ue = VEC[v][8:1]; gp = VEC[v][0]; a = ln*LINE_DW + off;
      preload(ln);
      if (cor) m_par[a] = ~m_par[a];
      o0 = n_out; r0 = n_req; f0 = n_flt;
      fch_vld = 1; fch_addr = AW'(a);
      @(negedge clk); fch_vld = 0;
      if (cor) begin wait_req(ln); send_beats(ln, ue, gp); end
      repeat (2) @(negedge clk);
      chk(n_out == o0 + 1, "R5 one answer per fetch", 64'(n_out - o0), 64'd1);
      chk(n_req == r0 + int'(cor), "R1 R2 request count", 64'(n_req - r0), 64'(cor));
      if (!cor) begin
        chk(g_data == pat(a) && !g_err && g_mid == 0, "R1 clean data", g_data, pat(a));
      end else begin
        chk(g_data == l2pat(a), "R5 forwarded data", g_data, l2pat(a));
        chk(g_err == ue[off], "R5 forwarded err", 64'(g_err), 64'(ue[off]));
        chk(g_mid == (ue[off] ? MID_W'(14'h100 + off) : '0), "R5 forwarded mid", 64'(g_mid), 64'(ue[off] ? 14'h100 + off : 0));
        for (int b = 0; b < LINE_DW; b++) begin
          int x; x = ln*LINE_DW + b;
          chk(m_data[x] == l2pat(x), "R3 line rewritten", m_data[x], l2pat(x));
          if (ue[b]) chk(m_par[x] == ~^l2pat(x) && m_mid[x] == MID_W'(14'h100 + b), "R4 poison stored",
                         {49'd0, m_par[x], m_mid[x]}, {49'd0, ~^l2pat(x), MID_W'(14'h100 + b)});
          else chk(m_par[x] == ^l2pat(x) && m_mid[x] == '0, "R3 clean parity", 64'(m_par[x]), 64'(^l2pat(x)));
        end
      end
      chk(n_flt == f0 && !sts_ue, "R6 R10 no report from fetch", 64'(n_flt - f0), 64'd0);
    end

    // R8: fetches during refill ignored
    begin
      int o0, r0;
      preload(6); preload(7);
      m_par[6*LINE_DW+4] = ~m_par[6*LINE_DW+4];
      m_par[7*LINE_DW+2] = ~m_par[7*LINE_DW+2];
      o0 = n_out; r0 = n_req;
      fch_vld = 1; fch_addr = AW'(6*LINE_DW+4);
      @(negedge clk); fch_vld = 0;
      wait_req(6);
      fch_addr = AW'(7*LINE_DW+2); fch_vld = 1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!fch_rdy, "R8 fetch stalled during refill", 64'(fch_rdy), 64'd0);
      end
      fch_vld = 0;
      send_beats(6, 8'h00, 1'b0);
      repeat (2) @(negedge clk);
      chk(n_req == r0 + 1, "R8 no second request", 64'(n_req - r0), 64'd1);
      chk(n_out == o0 + 1, "R8 no answer to stalled fetch", 64'(n_out - o0), 64'd1);
      chk(m_par[7*LINE_DW+2] != ^m_data[7*LINE_DW+2], "R8 other line untouched", 64'(m_par[7*LINE_DW+2]), 64'(~^m_data[7*LINE_DW+2]));
      chk(fch_rdy, "R2 ready restored after refill", 64'(fch_rdy), 64'd1);
    end

    // R10: clean completion
    begin
      int f0; f0 = n_flt;
      ret_vld = 1; ret_err = 0; ret_mid = 14'h0033;
      @(negedge clk); ret_vld = 0;
      @(negedge clk);
      chk(n_flt == f0 && !sts_ue, "R10 clean retire no fault", 64'(n_flt - f0), 64'd0);
    end

    // R9: poisoned completion
    ret_vld = 1; ret_err = 1; ret_mid = 14'h02A5;
    @(negedge clk); ret_vld = 0; ret_err = 0;
    chk(flt_vld && sts_ue && sts_mid == 14'h02A5, "R9 fault and status", {49'd0, flt_vld, sts_mid}, {49'd1, 14'h02A5});
    @(negedge clk);
    chk(!flt_vld && sts_ue, "R9 fault lasts one cycle", 64'(flt_vld), 64'd0);

    // R11: clear, then set wins over clear
    sts_clr = 1;
    @(negedge clk); sts_clr = 0;
    chk(!sts_ue && sts_mid == 0, "R11 clear", {49'd0, sts_ue, sts_mid}, 64'd0);
    sts_clr = 1; ret_vld = 1; ret_err = 1; ret_mid = 14'h1ABC;
    @(negedge clk); sts_clr = 0; ret_vld = 0; ret_err = 0;
    chk(sts_ue && sts_mid == 14'h1ABC, "R11 set beats clear", {49'd0, sts_ue, sts_mid}, {49'd1, 14'h1ABC});
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule